// File: doc/BRIEF.md
# Sequential Radix-2 Booth Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits (32 by default) and returns a signed product of twice that width. It trades speed for area. It spends one clock per multiplier bit and reuses a single narrow adder/subtractor on every step. It does not build a full partial-product array.

The multiplier operand is placed in the lower half of a double-width product register, and the upper half starts at zero. On each step the block looks at two bits: the lowest bit of the product register, and a saved flag holding the bit that was shifted out on the step before. The pair 10 subtracts the multiplicand from the upper half, and the pair 01 adds it. The pairs 00 and 11 leave the upper half unchanged. The whole register then moves right by one place, and its sign bit is copied in at the top. Because of this shift, negative operands need no separate sign correction.

A one-cycle `start` while the block is idle captures both operands. `busy` stays high for the iterations, and `done` pulses once when the product is ready. The product then holds its value until the next accepted start.

Top module: `booth_seq_mult`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `product` is all zeros.
- R2: When `start` is 1 and `busy` is 0 at a rising clock edge, both operands are captured and `busy` is 1 from that edge onward. Later changes on the operand inputs do not affect the result.
- R3: For every pair of signed operands, the `product` shown while `done` is 1 equals their exact signed product as a 2*WIDTH-bit two's-complement value. This includes the most negative value times itself, zero, and minus one.
- R4: After an accepted start, `busy` stays 1 for exactly WIDTH clock cycles. `done` goes to 1 at the same edge where `busy` drops.
- R5: `done` is 1 for exactly one cycle per operation and is never 1 while `busy` is 1.
- R6: A `start` pulse while `busy` is 1 is ignored. The operation keeps its original operands, and the latency is still WIDTH cycles.
- R7: After `done`, `product` keeps its value until the next accepted start, whatever the operand inputs do.
- R8: Booth recoding on the pair (current bit, previous bit) gives -6 × 6 = -36 and -6 × -2 = +12, with the operands sign-extended to WIDTH bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, accepted only while idle |
| multiplicand | input | WIDTH | Signed multiplicand operand |
| multiplier | input | WIDTH | Signed multiplier operand |
| busy | output | 1 | High while iterations are running |
| done | output | 1 | One-cycle pulse when the product is valid |
| product | output | 2*WIDTH | Signed product |

## Verification
The main function is tried with four kinds of operand pairs: the two small recoding examples, corner values, random values, and disturbed runs.

- The small examples put sign bits on both sides, so they show whether subtract-on-10 and add-on-01 are applied in the right order.
- The corner values catch specific faults. The most negative value squared overflows a plain 32-bit step result, so it shows whether the sign extension inside the step adder is correct. Zero and minus one operands exercise long runs of identical bits, so they show whether the 00 and 11 pairs are wrongly acted on.
- Random pairs of every sign combination check the step arithmetic in general.
- The disturbed runs pulse start and change the operand inputs during and after an operation. They separate correct operand capture and idle-only start acceptance from a design that restarts or tracks its inputs.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // Strobes sent from the sequencer to the datapath each cycle.
  typedef struct packed {
    logic load;  // capture operands, clear the accumulator half
    logic step;  // perform one recode/add/shift iteration
  } mulCtrl_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mulState_t;

endpackage

// File: rtl/booth_step.sv
// One Booth iteration on the upper half: recode the bit pair and
// add, subtract or pass, with one extra bit of headroom.
module booth_step #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] upperHalf,
  input  logic [WIDTH-1:0] mcand,
  input  logic             curBit,
  input  logic             prevBit,
  output logic [WIDTH:0]   stepOut
);
  logic [WIDTH:0] upperExt;
  logic [WIDTH:0] mcandExt;

  assign upperExt = {upperHalf[WIDTH-1], upperHalf};
  assign mcandExt = {mcand[WIDTH-1], mcand};

  always_comb begin
    unique case ({curBit, prevBit})
      2'b10:   stepOut = upperExt - mcandExt;  // run of ones begins
      2'b01:   stepOut = upperExt + mcandExt;  // run of ones ends
      default: stepOut = upperExt;             // inside a run
    endcase
  end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output mulCtrl_t ctrlBus,
  output logic     busy,
  output logic     done
);
  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_ITER = CNT_W'(WIDTH - 1);

  mulState_t         state;
  logic [CNT_W-1:0]  iterCnt;
  logic              doneReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            iterCnt <= '0;
          end
        end
        ST_RUN: begin
          if (iterCnt == LAST_ITER) begin
            state   <= ST_IDLE;
            doneReg <= 1'b1;
          end else begin
            iterCnt <= iterCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrlBus.load = (state == ST_IDLE) && start;
    ctrlBus.step = (state == ST_RUN);
  end

  assign busy = (state == ST_RUN);
  assign done = doneReg;
endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
  import booth_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  mulCtrl_t           ctrlBus,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic [2*WIDTH-1:0] product
);
  localparam int PW = 2 * WIDTH;

  logic [PW-1:0]    prodReg;   // upper: accumulator, lower: remaining multiplier
  logic [WIDTH-1:0] mcandReg;
  logic             prevBit;   // bit to the right of prodReg[0]
  logic [WIDTH:0]   stepOut;

  booth_step #(.WIDTH(WIDTH)) i_step (
    .upperHalf (prodReg[PW-1:WIDTH]),
    .mcand     (mcandReg),
    .curBit    (prodReg[0]),
    .prevBit   (prevBit),
    .stepOut   (stepOut)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodReg  <= '0;
      mcandReg <= '0;
      prevBit  <= 1'b0;
    end else if (ctrlBus.load) begin
      prodReg  <= {{WIDTH{1'b0}}, multiplier};
      mcandReg <= multiplicand;
      prevBit  <= 1'b0;
    end else if (ctrlBus.step) begin
      // arithmetic shift right of {stepOut, lower half}, keeping 2*WIDTH bits
      prodReg  <= {stepOut, prodReg[WIDTH-1:1]};
      prevBit  <= prodReg[0];
    end
  end

  assign product = prodReg;
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
  import booth_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  mulCtrl_t ctrlBus;

  booth_ctrl #(.WIDTH(WIDTH)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .ctrlBus (ctrlBus),
    .busy    (busy),
    .done    (done)
  );

  booth_datapath #(.WIDTH(WIDTH)) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrlBus      (ctrlBus),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .product      (product)
  );
endmodule

// File: rtl/booth_mult_chk.sv
module booth_mult_chk #(
  parameter int WIDTH = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [WIDTH-1:0]   multiplicand,
  input logic [WIDTH-1:0]   multiplier,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);
  localparam int CW = $clog2(WIDTH + 2) + 1;

  logic [WIDTH-1:0]          capA;
  logic [WIDTH-1:0]          capB;
  logic [CW-1:0]             busyCnt;
  logic signed [2*WIDTH-1:0] refProd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capA    <= '0;
      capB    <= '0;
      busyCnt <= '0;
    end else if (start && !busy) begin
      capA    <= multiplicand;
      capB    <= multiplier;
      busyCnt <= '0;
    end else if (busy) begin
      busyCnt <= busyCnt + 1'b1;
    end
  end

  always_comb begin
    refProd = $signed({{WIDTH{capA[WIDTH-1]}}, capA}) *
              $signed({{WIDTH{capB[WIDTH-1]}}, capB});
  end

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  assert_product_value_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (product == refProd));

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done && busyCnt == CW'(WIDTH)));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && busyCnt < CW'(WIDTH - 1)) |=> busy);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(product));
endmodule

bind booth_seq_mult booth_mult_chk #(.WIDTH(WIDTH)) i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .start        (start),
  .multiplicand (multiplicand),
  .multiplier   (multiplier),
  .busy         (busy),
  .done         (done),
  .product      (product)
);

// File: tb/test_booth_seq_mult.sv
module test_booth_seq_mult;
  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mcandIn = '0;
  logic [W-1:0]   mplierIn = '0;
  logic           busy;
  logic           done;
  logic [2*W-1:0] product;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  booth_seq_mult #(.WIDTH(W)) i_booth_seq_mult (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .multiplicand (mcandIn),
    .multiplier   (mplierIn),
    .busy         (busy),
    .done         (done),
    .product      (product)
  );

  always #4 clk = ~clk;  // 8 ns period

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL R4 watchdog: actual %0d cycles, expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] refMul(input logic [W-1:0] a, input logic [W-1:0] b);
    longint sa;
    longint sb;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    return 64'(sa * sb);
  endfunction

  // Runs one operation. disturb=1 pulses start and changes the operand
  // inputs in mid-run (R6, R2).
  task automatic runMul(input logic [W-1:0] a, input logic [W-1:0] b,
                        input string req, input bit disturb);
    int n;
    logic [63:0] exp;
    exp = refMul(a, b);
    @(negedge clk);
    mcandIn = a; mplierIn = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2", "busy after accepted start", 64'(busy), 64'd1);
    n = 0;
    while (busy === 1'b1 && n < W + 8) begin
      n = n + 1;
      if (disturb && n == 5) begin
        start = 1'b1; mcandIn = ~a; mplierIn = b + 32'd7;
      end else if (disturb && n == 6) begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(n == W, disturb ? "R6" : "R4", "busy cycle count", 64'(n), 64'(W));
    check(done === 1'b1, "R4", "done when busy drops", 64'(done), 64'd1);
    check(product === exp, req, "product value", product, exp);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R5", "done one-cycle pulse",
          64'({busy, done}), 64'd0);
  endtask

  task automatic testReset;
    check(busy === 1'b0, "R1", "busy after reset", 64'(busy), 64'd0);
    check(done === 1'b0, "R1", "done after reset", 64'(done), 64'd0);
    check(product === '0, "R1", "product after reset", product, 64'd0);
  endtask

  task automatic testBoothExamples;
    runMul(-32'sd6, 32'sd6, "R8", 1'b0);   // -36
    check(product === 64'hFFFF_FFFF_FFFF_FFDC, "R8", "-6 x 6", product,
          64'hFFFF_FFFF_FFFF_FFDC);
    runMul(-32'sd6, -32'sd2, "R8", 1'b0);  // +12
    check(product === 64'd12, "R8", "-6 x -2", product, 64'd12);
  endtask

  task automatic testCorners;
    runMul(32'h8000_0000, 32'h8000_0000, "R3", 1'b0);
    runMul(32'h8000_0000, 32'h7FFF_FFFF, "R3", 1'b0);
    runMul(32'h0, 32'hDEAD_BEEF, "R3", 1'b0);
    runMul(32'h1234_5678, 32'h0, "R3", 1'b0);
    runMul(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3", 1'b0);
    runMul(32'hFFFF_FFFF, 32'h7FFF_FFFF, "R3", 1'b0);
    runMul(32'h7FFF_FFFF, 32'h7FFF_FFFF, "R3", 1'b0);
  endtask

  task automatic testRandom;
    for (int i = 0; i < 40; i++) begin
      runMul($urandom, $urandom, "R3", 1'b0);
    end
  endtask

  task automatic testDisturbedRun;
    // start pulse and operand changes mid-run must not restart or alter it
    runMul(32'hFFFF_FF85, 32'h0000_3039, "R6", 1'b1);
  endtask

  task automatic testHold;
    logic [63:0] held;
    runMul(32'h0001_0001, 32'hFFFF_0003, "R3", 1'b0);
    held = product;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      mcandIn = $urandom; mplierIn = $urandom;
    end
    @(negedge clk);
    check(product === held, "R7", "product held while idle", product, held);
    check(busy === 1'b0, "R7", "no operation without start", 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testBoothExamples();
    testCorners();
    testRandom();
    testDisturbedRun();
    testHold();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule